// File: doc/BRIEF.md
# UART FIFO DMA Handshake Logic

This block derives, for one UART channel, the two active-low DMA request lines (transmit-ready and receive-ready), the FIFO-driven transmit and receive interrupt requests, and three line-status flags read by software in polled operation. It does not hold any data. The FIFOs, shift registers and register decoding sit outside the block. They present only occupancy counts, holding-register flags, a shift-register-empty flag and per-FIFO reset strobes.

A mode bit selects between single-transfer handshaking and block-transfer handshaking. In single-transfer mode, each request line follows a plain empty or not-empty condition. In block mode, transmit-ready asks for data while any transmit slot is free. Receive-ready uses hysteresis: it asserts at the programmed trigger level and releases only once the receive FIFO is drained. When the FIFOs are disabled, the one-deep holding registers take the place of the FIFOs, with a depth of 1 and a trigger of 1. Every output is registered.

Top module: `uart_dma_handshake`

## Requirements
- R1: With `blk_mode_i`=0, `txrdy_n_o` is 0 exactly when the transmit occupancy is 0. With FIFOs enabled, transmit occupancy is `tx_cnt_i`. With FIFOs disabled, it is 0 when `thr_empty_i`=1 and 1 otherwise.
- R2: With `blk_mode_i`=0, `rxrdy_n_o` is 0 exactly when the receive occupancy is at least 1. With FIFOs enabled, receive occupancy is `rx_cnt_i`. With FIFOs disabled, it is 1 when `rhr_full_i`=1 and 0 otherwise.
- R3: With `blk_mode_i`=1, `txrdy_n_o` is 0 exactly when the transmit occupancy is below the effective depth. The effective depth is 16 with FIFOs enabled and 1 with FIFOs disabled.
- R4: With `blk_mode_i`=1, `rxrdy_n_o` goes to 0 when the receive occupancy reaches the trigger level. It stays 0 while the occupancy remains nonzero, even below the trigger. It returns to 1 only when the occupancy is 0.
- R5: `trig_sel_i` selects the receive trigger level as follows: 00 gives 1, 01 gives 4, 10 gives 8, and 11 gives 14. With FIFOs disabled, the trigger is 1 regardless of `trig_sel_i`.
- R6: `rx_irq_o` is `rx_ie_i` AND a receive condition. In single mode, the condition is occupancy ≥ 1. In block mode, it is occupancy ≥ trigger, and it stays true for every occupancy above the trigger up to full.
- R7: `tx_irq_o` is `tx_ie_i` AND (transmit occupancy is 0).
- R8: With `rx_ie_i`=0 and `tx_ie_i`=0 (polled operation), neither interrupt output is ever 1.
- R9: `data_ready_o` is 1 when the receive occupancy is nonzero. `thr_empty_o` is 1 when the transmit occupancy is 0. `tx_idle_o` is 1 when the transmit occupancy is 0 and `tsr_empty_i`=1. None of these depends on the enables or the mode.
- R10: While `rst_ni`=0, the outputs take these values: `txrdy_n_o`=1, `rxrdy_n_o`=1, both interrupts 0, `data_ready_o`=0, `thr_empty_o`=1 and `tx_idle_o`=1.
- R11: A cycle with `tx_fifo_rst_i`=1 or `rx_fifo_rst_i`=1 evaluates that side as if its occupancy were 0. On the receive side, this also clears a pending block-mode receive-ready hold.
- R12: Every output reflects the inputs sampled at the previous rising clock edge. Between edges, the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1 = FIFOs in use, 0 = one-deep holding registers |
| blk_mode_i | input | 1 | 0 = single-transfer, 1 = block-transfer handshaking |
| trig_sel_i | input | 2 | Receive trigger level code |
| rx_ie_i | input | 1 | Receive interrupt enable |
| tx_ie_i | input | 1 | Transmit interrupt enable |
| tx_cnt_i | input | 5 | Transmit FIFO occupancy |
| rx_cnt_i | input | 5 | Receive FIFO occupancy |
| thr_empty_i | input | 1 | Transmit holding register empty (FIFOs disabled) |
| rhr_full_i | input | 1 | Receive holding register loaded (FIFOs disabled) |
| tsr_empty_i | input | 1 | Transmit shift register empty |
| tx_fifo_rst_i | input | 1 | Transmit FIFO reset strobe |
| rx_fifo_rst_i | input | 1 | Receive FIFO reset strobe |
| txrdy_n_o | output | 1 | Transmit DMA request, active low |
| rxrdy_n_o | output | 1 | Receive DMA request, active low |
| tx_irq_o | output | 1 | Transmit interrupt request |
| rx_irq_o | output | 1 | Receive interrupt request |
| data_ready_o | output | 1 | Receive data available flag |
| thr_empty_o | output | 1 | Transmit FIFO empty flag |
| tx_idle_o | output | 1 | Transmit FIFO and shift register both empty |

## Verification
A receive FIFO reset strobe and a trigger-level crossing can land in the same cycle. The block-mode hold may also already be set when the strobe arrives. Both orderings must let the strobe win. The sweep raises the receive reset strobe partway down a falling occupancy ramp, while the count is still above several of the trigger levels. The arithmetic model then expects `rxrdy_n_o` high for that cycle, and re-asserted afterwards only if the remaining count is still at or above the trigger. A transmit reset strobe is treated the same way against the block-mode free-slot rule and the empty interrupt.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;
  typedef enum logic [1:0] {
    TRIG_A = 2'b00,
    TRIG_B = 2'b01,
    TRIG_C = 2'b10,
    TRIG_D = 2'b11
  } trig_sel_e;
endpackage

// File: rtl/uart_dma_occ_sel.sv
module uart_dma_occ_sel #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             fifo_en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             hreg_busy_i,
  input  logic             flush_i,
  output logic [CNT_W-1:0] occ_o
);
  localparam logic [CNT_W-1:0] DepthC = CNT_W'(DEPTH);

  always_comb begin
    if (flush_i)        occ_o = '0;
    else if (!fifo_en_i) occ_o = hreg_busy_i ? CNT_W'(1) : '0;
    else if (cnt_i > DepthC) occ_o = DepthC;  // clamp stray counts
    else                occ_o = cnt_i;
  end
endmodule

// File: rtl/uart_dma_tx_ctl.sv
module uart_dma_tx_ctl #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             blk_mode_i,
  input  logic             ie_i,
  input  logic             tsr_empty_i,
  input  logic [CNT_W-1:0] occ_i,
  output logic             rdy_n_o,
  output logic             irq_o,
  output logic             empty_o,
  output logic             idle_o
);
  logic [CNT_W-1:0] depth_lim;
  logic             empty, rdy;

  always_comb begin
    depth_lim = fifo_en_i ? CNT_W'(DEPTH) : CNT_W'(1);
    empty     = (occ_i == '0);
    rdy       = blk_mode_i ? (occ_i < depth_lim) : empty;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_n_o <= 1'b1;
      irq_o   <= 1'b0;
      empty_o <= 1'b1;
      idle_o  <= 1'b1;
    end else begin
      rdy_n_o <= ~rdy;
      irq_o   <= ie_i & empty;
      empty_o <= empty;
      idle_o  <= empty & tsr_empty_i;
    end
  end
endmodule

// File: rtl/uart_dma_rx_ctl.sv
module uart_dma_rx_ctl
  import uart_dma_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int TRIG_A_LVL = 1,
  parameter int TRIG_B_LVL = 4,
  parameter int TRIG_C_LVL = 8,
  parameter int TRIG_D_LVL = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             blk_mode_i,
  input  logic             ie_i,
  input  trig_sel_e        trig_sel_i,
  input  logic [CNT_W-1:0] occ_i,
  output logic             rdy_n_o,
  output logic             irq_o,
  output logic             avail_o
);
  logic [CNT_W-1:0] trig_lvl;
  logic             nonempty, at_trig, hold_q, hold_d, rdy;

  always_comb begin
    unique case (trig_sel_i)
      TRIG_A:  trig_lvl = CNT_W'(TRIG_A_LVL);
      TRIG_B:  trig_lvl = CNT_W'(TRIG_B_LVL);
      TRIG_C:  trig_lvl = CNT_W'(TRIG_C_LVL);
      default: trig_lvl = CNT_W'(TRIG_D_LVL);
    endcase
    if (!fifo_en_i) trig_lvl = CNT_W'(1);
    nonempty = (occ_i != '0);
    at_trig  = (occ_i >= trig_lvl);
    // hysteresis: set at trigger, clear only when drained
    if (!nonempty)   hold_d = 1'b0;
    else if (at_trig) hold_d = 1'b1;
    else             hold_d = hold_q;
    rdy = blk_mode_i ? hold_d : nonempty;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= 1'b0;
      rdy_n_o <= 1'b1;
      irq_o   <= 1'b0;
      avail_o <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      rdy_n_o <= ~rdy;
      irq_o   <= ie_i & (blk_mode_i ? at_trig : nonempty);
      avail_o <= nonempty;
    end
  end
endmodule

// File: rtl/uart_dma_handshake.sv
module uart_dma_handshake
  import uart_dma_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int CNT_W      = $clog2(DEPTH + 1),
  parameter int TRIG_A_LVL = 1,
  parameter int TRIG_B_LVL = 4,
  parameter int TRIG_C_LVL = 8,
  parameter int TRIG_D_LVL = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             blk_mode_i,
  input  logic [1:0]       trig_sel_i,
  input  logic             rx_ie_i,
  input  logic             tx_ie_i,
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic             thr_empty_i,
  input  logic             rhr_full_i,
  input  logic             tsr_empty_i,
  input  logic             tx_fifo_rst_i,
  input  logic             rx_fifo_rst_i,
  output logic             txrdy_n_o,
  output logic             rxrdy_n_o,
  output logic             tx_irq_o,
  output logic             rx_irq_o,
  output logic             data_ready_o,
  output logic             thr_empty_o,
  output logic             tx_idle_o
);
  logic [CNT_W-1:0] tx_occ, rx_occ;

  uart_dma_occ_sel #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx_occ (
    .fifo_en_i  (fifo_en_i),
    .cnt_i      (tx_cnt_i),
    .hreg_busy_i(~thr_empty_i),
    .flush_i    (tx_fifo_rst_i),
    .occ_o      (tx_occ)
  );

  uart_dma_occ_sel #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx_occ (
    .fifo_en_i  (fifo_en_i),
    .cnt_i      (rx_cnt_i),
    .hreg_busy_i(rhr_full_i),
    .flush_i    (rx_fifo_rst_i),
    .occ_o      (rx_occ)
  );

  uart_dma_tx_ctl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fifo_en_i  (fifo_en_i),
    .blk_mode_i (blk_mode_i),
    .ie_i       (tx_ie_i),
    .tsr_empty_i(tsr_empty_i),
    .occ_i      (tx_occ),
    .rdy_n_o    (txrdy_n_o),
    .irq_o      (tx_irq_o),
    .empty_o    (thr_empty_o),
    .idle_o     (tx_idle_o)
  );

  uart_dma_rx_ctl #(
    .DEPTH(DEPTH), .CNT_W(CNT_W),
    .TRIG_A_LVL(TRIG_A_LVL), .TRIG_B_LVL(TRIG_B_LVL),
    .TRIG_C_LVL(TRIG_C_LVL), .TRIG_D_LVL(TRIG_D_LVL)
  ) u_rx_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fifo_en_i (fifo_en_i),
    .blk_mode_i(blk_mode_i),
    .ie_i      (rx_ie_i),
    .trig_sel_i(trig_sel_e'(trig_sel_i)),
    .occ_i     (rx_occ),
    .rdy_n_o   (rxrdy_n_o),
    .irq_o     (rx_irq_o),
    .avail_o   (data_ready_o)
  );
endmodule

// File: rtl/uart_dma_handshake_chk.sv
module uart_dma_handshake_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fifo_en_i,
  input logic             blk_mode_i,
  input logic [1:0]       trig_sel_i,
  input logic             rx_ie_i,
  input logic             tx_ie_i,
  input logic [CNT_W-1:0] tx_cnt_i,
  input logic [CNT_W-1:0] rx_cnt_i,
  input logic             tx_fifo_rst_i,
  input logic             rx_fifo_rst_i,
  input logic             txrdy_n_o,
  input logic             rxrdy_n_o,
  input logic             tx_irq_o,
  input logic             rx_irq_o,
  input logic             data_ready_o,
  input logic             thr_empty_o,
  input logic             tx_idle_o
);
  logic past_ok;
  logic [CNT_W-1:0] trig;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  always_comb begin
    case (trig_sel_i)
      2'b00:   trig = CNT_W'(1);
      2'b01:   trig = CNT_W'(4);
      2'b10:   trig = CNT_W'(8);
      default: trig = CNT_W'(14);
    endcase
  end

  // R1
  a_r1_single_tx_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(fifo_en_i && !blk_mode_i && !tx_fifo_rst_i && tx_cnt_i == '0)
    |-> !txrdy_n_o);

  // R4
  a_r4_blk_rx_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(fifo_en_i && blk_mode_i && rx_cnt_i == '0) |-> rxrdy_n_o);

  // R5
  a_r5_blk_rx_trigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(fifo_en_i && blk_mode_i && !rx_fifo_rst_i && rx_cnt_i >= trig
                     && rx_cnt_i <= CNT_W'(16))
    |-> !rxrdy_n_o);

  // R8
  a_r8_polled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!rx_ie_i && !tx_ie_i) |-> (!rx_irq_o && !tx_irq_o));

  // R9
  a_r9_idle_implies_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_idle_o |-> thr_empty_o);

  // R11
  a_r11_rx_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(rx_fifo_rst_i) |-> (rxrdy_n_o && !data_ready_o && !rx_irq_o));

  // R11
  a_r11_tx_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(tx_fifo_rst_i) |-> thr_empty_o);
endmodule

bind uart_dma_handshake uart_dma_handshake_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fifo_en_i    (fifo_en_i),
  .blk_mode_i   (blk_mode_i),
  .trig_sel_i   (trig_sel_i),
  .rx_ie_i      (rx_ie_i),
  .tx_ie_i      (tx_ie_i),
  .tx_cnt_i     (tx_cnt_i),
  .rx_cnt_i     (rx_cnt_i),
  .tx_fifo_rst_i(tx_fifo_rst_i),
  .rx_fifo_rst_i(rx_fifo_rst_i),
  .txrdy_n_o    (txrdy_n_o),
  .rxrdy_n_o    (rxrdy_n_o),
  .tx_irq_o     (tx_irq_o),
  .rx_irq_o     (rx_irq_o),
  .data_ready_o (data_ready_o),
  .thr_empty_o  (thr_empty_o),
  .tx_idle_o    (tx_idle_o)
);

// File: tb/uart_dma_handshake_tb.sv
module uart_dma_handshake_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b1, blk = 1'b0, rx_ie = 1'b1, tx_ie = 1'b1;
  logic [1:0] tsel = 2'b00;
  logic [4:0] tx_cnt = 5'd3, rx_cnt = 5'd7;
  logic thr_e = 1'b0, rhr_f = 1'b1, tsr_e = 1'b0, tx_rst = 1'b0, rx_rst = 1'b0;
  logic txrdy_n, rxrdy_n, tx_irq, rx_irq, dr, te, idle;
  int n_chk = 0, n_err = 0;
  bit m_hold = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  uart_dma_handshake u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .blk_mode_i(blk),
    .trig_sel_i(tsel), .rx_ie_i(rx_ie), .tx_ie_i(tx_ie),
    .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt), .thr_empty_i(thr_e),
    .rhr_full_i(rhr_f), .tsr_empty_i(tsr_e), .tx_fifo_rst_i(tx_rst),
    .rx_fifo_rst_i(rx_rst), .txrdy_n_o(txrdy_n), .rxrdy_n_o(rxrdy_n),
    .tx_irq_o(tx_irq), .rx_irq_o(rx_irq), .data_ready_o(dr),
    .thr_empty_o(te), .tx_idle_o(idle)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0b exp=%0b (fe=%0b blk=%0b ts=%0d tx=%0d rx=%0d)",
               tag, act, exp, fifo_en, blk, tsel, tx_cnt, rx_cnt);
    end
  endtask

  // arithmetic model of one edge; inputs must be stable
  task automatic step_and_check();
    int txo, rxo, dep, trg;
    bit e_txrdy, e_rdy, e_rxirq, hold_d;
    txo = tx_rst ? 0 : (fifo_en ? int'(tx_cnt) : (thr_e ? 0 : 1));
    rxo = rx_rst ? 0 : (fifo_en ? int'(rx_cnt) : (rhr_f ? 1 : 0));
    dep = fifo_en ? 16 : 1;
    trg = !fifo_en ? 1 : (tsel == 2'd0 ? 1 : tsel == 2'd1 ? 4 : tsel == 2'd2 ? 8 : 14);
    hold_d = (rxo == 0) ? 1'b0 : (rxo >= trg) ? 1'b1 : m_hold;
    e_txrdy = blk ? (txo < dep) : (txo == 0);
    e_rdy   = blk ? hold_d : (rxo != 0);
    e_rxirq = rx_ie && (blk ? (rxo >= trg) : (rxo != 0));
    @(posedge clk);
    m_hold = hold_d;
    #1;
    chk(blk ? "R3 txrdy block" : "R1 txrdy single", txrdy_n, !e_txrdy);
    chk(blk ? "R4/R5 rxrdy block" : "R2 rxrdy single", rxrdy_n, !e_rdy);
    chk(rx_ie ? "R6 rx_irq" : "R8 rx_irq polled", rx_irq, e_rxirq);
    chk(tx_ie ? "R7 tx_irq" : "R8 tx_irq polled", tx_irq, tx_ie && (txo == 0));
    chk((rx_rst || tx_rst) ? "R11 data_ready" : "R9 data_ready", dr, rxo != 0);
    chk((rx_rst || tx_rst) ? "R11 thr_empty" : "R9 thr_empty", te, txo == 0);
    chk("R9 tx_idle", idle, (txo == 0) && tsr_e);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // R10: reset values with busy inputs
    #20;
    chk("R10 txrdy_n", txrdy_n, 1'b1);
    chk("R10 rxrdy_n", rxrdy_n, 1'b1);
    chk("R10 tx_irq", tx_irq, 1'b0);
    chk("R10 rx_irq", rx_irq, 1'b0);
    chk("R10 data_ready", dr, 1'b0);
    chk("R10 thr_empty", te, 1'b1);
    chk("R10 tx_idle", idle, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    m_hold = 1'b0;

    for (int fe = 0; fe < 2; fe++)
      for (int md = 0; md < 2; md++)
        for (int ts = 0; ts < 4; ts++)
          for (int ie = 0; ie < 4; ie++)
            for (int st = 0; st < 34; st++) begin
              int c;
              c = (st <= 16) ? st : 33 - st;
              @(negedge clk);
              fifo_en = fe[0]; blk = md[0]; tsel = ts[1:0];
              rx_ie = ie[0]; tx_ie = ie[1];
              rx_cnt = 5'(c); tx_cnt = 5'(16 - c);
              rhr_f = c[0]; thr_e = ~c[1]; tsr_e = st[2];
              rx_rst = (st == 24);  // strobe with count 9, above several triggers
              tx_rst = (st == 20);
              step_and_check();
            end

    // R12: output holds between edges, updates at next edge
    @(negedge clk);
    fifo_en = 1'b1; blk = 1'b0; rx_rst = 1'b0; tx_rst = 1'b0;
    rx_cnt = 5'd0; tx_cnt = 5'd5;
    step_and_check();
    @(negedge clk);
    rx_cnt = 5'd2;
    #1 chk("R12 data_ready before edge", dr, 1'b0);
    step_and_check();
    chk("R12 data_ready after edge", dr, 1'b1);

    // R4 hold below trigger, then R11 flush drops it
    @(negedge clk);
    blk = 1'b1; tsel = 2'b10; rx_cnt = 5'd8;
    step_and_check();
    @(negedge clk);
    rx_cnt = 5'd3;
    step_and_check();
    chk("R4 hold below trigger", rxrdy_n, 1'b0);
    @(negedge clk);
    rx_rst = 1'b1;
    step_and_check();
    chk("R11 flush releases rxrdy", rxrdy_n, 1'b1);
    @(negedge clk);
    rx_rst = 1'b0;
    step_and_check();
    chk("R11 hold stays cleared below trigger", rxrdy_n, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule